// File: doc/BRIEF.md
# Compressed-Aware Instruction Fetch Aligner

This block produces one instruction per request from a memory that can be read either as a 16-bit halfword or as an aligned 32-bit word. The instruction stream may mix 16-bit compressed instructions with 32-bit ones. A requester presents a fetch address and a compressed-mode enable. The block returns the instruction bits, a flag that marks a 16-bit instruction, and a one-cycle valid strobe.

When compressed mode is on and the address falls in the upper halfword of a 32-bit word, the instruction may straddle the word boundary. In that case the block first reads only the halfword at the fetch address. It then inspects that halfword's encoding. If the instruction is 32 bits long, it makes a second halfword read at the next address. In every other case it makes one aligned word read.

The memory answers one cycle after each request. A halfword read returns its data in the low 16 bits of the read data.

The controller has four states:
- IDLE: accepts a fetch and issues the first read in the same cycle.
- READ_LO: captures the first result. From here it takes either READ_LO→READ_HI, issuing the second read when needed, or READ_LO→DONE.
- READ_HI: captures the upper halfword, then takes READ_HI→DONE.
- DONE: pulses valid, then takes DONE→IDLE.

Top module: `ifetch_align`

## Requirements
- R1: A fetch is accepted only in a cycle where `fetch_ready` is 1 and `fetch_req` is 1, and the first memory read is issued in that same cycle. `fetch_req` has no effect while `fetch_ready` is 0.
- R2: When `cmode_en` is 1 and `fetch_addr[1:0]` is 2'b10 (split path), the first read is a halfword read (`mem_wide`=0) at `fetch_addr`. Its data forms `insn_bits[15:0]`.
- R3: On the split path, if bits [1:0] of the first halfword are both 1, a second halfword read is made at `fetch_addr`+2 and its data forms `insn_bits[31:16]`. In that case `insn_short` is 0 and `insn_valid` rises three cycles after the accepting cycle.
- R4: On the split path, if bits [1:0] of the first halfword are not both 1, no second read is made and `insn_short` is 1. `insn_valid` rises two cycles after the accepting cycle.
- R5: In all other cases there is a single word read (`mem_wide`=1) at `fetch_addr` with bits [1:0] cleared. `insn_bits` equals the returned 32 bits, `insn_short` is 0, and `insn_valid` rises two cycles after the accepting cycle.
- R6: Whenever `insn_short` is 1, `insn_bits[31:16]` is zero.
- R7: `insn_valid` is high for exactly one cycle per accepted fetch. No memory read is issued in that cycle. `insn_bits` and `insn_short` hold until the next fetch completes.
- R8: After reset, `fetch_ready` is 1, and `insn_valid`, `mem_req`, `insn_short` and `insn_bits` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | ADDR_W | Byte address of the instruction |
| cmode_en | input | 1 | Compressed-mode enable |
| fetch_ready | output | 1 | High when a fetch can be accepted |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read byte address |
| mem_wide | output | 1 | 1 = 32-bit word read, 0 = 16-bit halfword read |
| mem_rdata | input | 32 | Read data, one cycle after `mem_req`; a halfword in bits 15:0 |
| insn_bits | output | 32 | Assembled instruction |
| insn_short | output | 1 | Instruction is a 16-bit compressed one |
| insn_valid | output | 1 | One-cycle strobe: instruction ready |

## Verification
The bench builds the block with `ADDR_W` = 12. This keeps the modelled memory to a 64-byte window, which is mirrored across the address space. With that window, fetches at offset 0 and offset 2 of a word are reachable with the mode enable both on and off. So are a 32-bit instruction that straddles a word boundary and a compressed instruction in the last halfword of the window. The bench observes the request address, the access width and the number of reads per fetch at the memory port, so the second-read decision is checked at the ports and not inferred.

// File: rtl/ifa_pkg.sv
package ifa_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_READ_LO = 2'd1,
        ST_READ_HI = 2'd2,
        ST_DONE    = 2'd3
    } ifa_state_e;

    // A halfword opens a 16-bit instruction unless both low bits are set.
    function automatic logic half_is_short(input logic [HALF_W-1:0] h);
        return h[1:0] != 2'b11;
    endfunction

endpackage

// File: rtl/ifa_fsm.sv
module ifa_fsm
    import ifa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       need_hi,
    output logic       ready,
    output logic       cap_lo,
    output logic       cap_hi,
    output logic       done
);

    ifa_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_READ_LO;
            ST_READ_LO: state_d = need_hi ? ST_READ_HI : ST_DONE;
            ST_READ_HI: state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready  = 1'b0;
        cap_lo = 1'b0;
        cap_hi = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE:    ready  = 1'b1;
            ST_READ_LO: cap_lo = 1'b1;
            ST_READ_HI: cap_hi = 1'b1;
            ST_DONE:    done   = 1'b1;
        endcase
    end

endmodule

// File: rtl/ifa_dpath.sv
module ifa_dpath
    import ifa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              cmode_en,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              split_now,
    output logic              need_hi,
    output logic [ADDR_W-1:0] hi_addr,
    output logic [WORD_W-1:0] insn_q,
    output logic              short_q
);

    logic [ADDR_W-1:0] addr_q;
    logic              split_q;
    logic              lo_short;

    assign split_now = cmode_en && (fetch_addr[1:0] == 2'b10);
    assign lo_short  = half_is_short(mem_rdata[HALF_W-1:0]);
    assign need_hi   = cap_lo && split_q && !lo_short;
    assign hi_addr   = addr_q + ADDR_W'(2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            split_q <= 1'b0;
        end else if (start) begin
            addr_q  <= fetch_addr;
            split_q <= split_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            insn_q  <= '0;
            short_q <= 1'b0;
        end else if (cap_lo) begin
            if (split_q) begin
                insn_q  <= {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]};
                short_q <= lo_short;
            end else begin
                insn_q  <= mem_rdata;
                short_q <= 1'b0;
            end
        end else if (cap_hi) begin
            insn_q[WORD_W-1:HALF_W] <= mem_rdata[HALF_W-1:0];
        end
    end

endmodule

// File: rtl/ifetch_align.sv
module ifetch_align
    import ifa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              cmode_en,
    output logic              fetch_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wide,
    input  logic [31:0]       mem_rdata,
    output logic [31:0]       insn_bits,
    output logic              insn_short,
    output logic              insn_valid
);

    logic              start, need_hi, split_now, cap_lo, cap_hi;
    logic [ADDR_W-1:0] hi_addr;

    assign start = fetch_ready && fetch_req;

    ifa_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .need_hi (need_hi),
        .ready   (fetch_ready),
        .cap_lo  (cap_lo),
        .cap_hi  (cap_hi),
        .done    (insn_valid)
    );

    ifa_dpath #(.ADDR_W(ADDR_W)) u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .fetch_addr (fetch_addr),
        .cmode_en   (cmode_en),
        .cap_lo     (cap_lo),
        .cap_hi     (cap_hi),
        .mem_rdata  (mem_rdata),
        .split_now  (split_now),
        .need_hi    (need_hi),
        .hi_addr    (hi_addr),
        .insn_q     (insn_bits),
        .short_q    (insn_short)
    );

    assign mem_req  = start || need_hi;
    assign mem_wide = fetch_ready && !split_now;

    always_comb begin
        if (!fetch_ready)   mem_addr = hi_addr;
        else if (split_now) mem_addr = fetch_addr;
        else                mem_addr = {fetch_addr[ADDR_W-1:2], 2'b00};
    end

endmodule

// File: rtl/ifa_checker.sv
module ifa_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_req,
    input logic              fetch_ready,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_wide,
    input logic [31:0]       insn_bits,
    input logic              insn_short,
    input logic              insn_valid
);

    AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ready && fetch_req) |-> mem_req);                          // R1
    AST_BUSY_READ_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !fetch_ready) |-> (!mem_wide && mem_addr[1:0] == 2'b00)); // R3
    AST_WIDE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_wide) |-> (mem_addr[1:0] == 2'b00));              // R5
    AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        insn_short |-> (insn_bits[31:16] == 16'h0));                      // R6
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid |=> !insn_valid);                                      // R7
    AST_VALID_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid |-> !mem_req);                                         // R7
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ready && !$rose(fetch_ready)) |-> ($stable(insn_bits) && $stable(insn_short))); // R7

endmodule

bind ifetch_align ifa_checker #(.ADDR_W(ADDR_W)) u_ifa_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_req   (fetch_req),
    .fetch_ready (fetch_ready),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_wide    (mem_wide),
    .insn_bits   (insn_bits),
    .insn_short  (insn_short),
    .insn_valid  (insn_valid)
);

// File: tb/tb_ifetch_align.sv
`timescale 1ns/1ps
module tb_ifetch_align;

    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_req = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          cmode_en = 1'b0;
    logic          fetch_ready, mem_req, mem_wide, insn_short, insn_valid;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata = '0;
    logic [31:0]   insn_bits;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ifetch_align #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .cmode_en(cmode_en), .fetch_ready(fetch_ready), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_wide(mem_wide), .mem_rdata(mem_rdata),
        .insn_bits(insn_bits), .insn_short(insn_short), .insn_valid(insn_valid)
    );

    // memory model: 32 halfwords, one-cycle read latency
    logic [15:0]   hw [32];
    int            reads;
    logic [AW-1:0] req_addr [2];
    logic          req_wide [2];

    always @(posedge clk) begin
        if (mem_req) begin
            if (reads < 2) begin
                req_addr[reads] <= mem_addr;
                req_wide[reads] <= mem_wide;
            end
            reads <= reads + 1;
            if (mem_wide) mem_rdata <= {hw[mem_addr[5:1] + 5'd1], hw[mem_addr[5:1]]};
            else          mem_rdata <= {16'h0, hw[mem_addr[5:1]]};
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // {addr[11:0], cmode, insn[31:0], short, latency[2:0], reads[1:0]}
    localparam logic [50:0] VEC [9] = '{
        {12'd0,  1'b1, 32'h00A00093, 1'b0, 3'd1, 2'd1},
        {12'd6,  1'b1, 32'h00B50513, 1'b0, 3'd2, 2'd2},
        {12'd2,  1'b1, 32'h000000A0, 1'b1, 3'd1, 2'd1},
        {12'd2,  1'b0, 32'h00A00093, 1'b0, 3'd1, 2'd1},
        {12'd4,  1'b1, 32'h05134505, 1'b0, 3'd1, 2'd1},
        {12'd10, 1'b1, 32'h00008082, 1'b1, 3'd1, 2'd1},
        {12'd14, 1'b1, 32'h1234FFFF, 1'b0, 3'd2, 2'd2},
        {12'd6,  1'b0, 32'h05134505, 1'b0, 3'd1, 2'd1},
        {12'd62, 1'b1, 32'h00000001, 1'b1, 3'd1, 2'd1}
    };

    task automatic run_fetch(input logic [AW-1:0] a, input logic cm,
                             output int lat, output logic [31:0] ins, output logic sh);
        @(negedge clk);
        reads = 0;
        fetch_req  = 1'b1;
        fetch_addr = a;
        cmode_en   = cm;
        @(posedge clk);
        @(negedge clk);
        fetch_req = 1'b0;
        lat = 0;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (insn_valid) break;
        end
        ins = insn_bits;
        sh  = insn_short;
    endtask

    initial begin
        #(4 * 5000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [31:0] ins;
        logic sh;
        for (int i = 0; i < 32; i++) hw[i] = 16'h0;
        hw[0] = 16'h0093; hw[1] = 16'h00A0; hw[2] = 16'h4505; hw[3] = 16'h0513;
        hw[4] = 16'h00B5; hw[5] = 16'h8082; hw[7] = 16'hFFFF; hw[8] = 16'h1234;
        hw[31] = 16'h0001;
        reads = 0;

        #1;
        chk("R8 ready", 32'(fetch_ready), 32'd1);
        chk("R8 valid", 32'(insn_valid), 32'd0);
        chk("R8 mem_req", 32'(mem_req), 32'd0);
        chk("R8 insn", insn_bits, 32'h0);
        chk("R8 short", 32'(insn_short), 32'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        foreach (VEC[i]) begin
            logic [AW-1:0] a;
            logic cm, split;
            a = VEC[i][50:39];
            cm = VEC[i][38];
            split = cm && (a[1:0] == 2'b10);
            run_fetch(a, cm, lat, ins, sh);
            if (split) begin
                chk("R2 first addr", 32'(req_addr[0]), 32'(a));
                chk("R2 first wide", 32'(req_wide[0]), 32'd0);
                chk("R2 insn", ins, VEC[i][37:6]);
                if (VEC[i][1:0] == 2'd2) begin
                    chk("R3 second addr", 32'(req_addr[1]), 32'(a + AW'(2)));
                    chk("R3 second wide", 32'(req_wide[1]), 32'd0);
                    chk("R3 latency", 32'(lat), 32'(VEC[i][4:2]));
                    chk("R3 reads", 32'(reads), 32'(VEC[i][1:0]));
                    chk("R3 short", 32'(sh), 32'(VEC[i][5]));
                end else begin
                    chk("R4 latency", 32'(lat), 32'(VEC[i][4:2]));
                    chk("R4 reads", 32'(reads), 32'(VEC[i][1:0]));
                    chk("R4 short", 32'(sh), 32'(VEC[i][5]));
                    chk("R6 upper zero", 32'(ins[31:16]), 32'h0);
                end
            end else begin
                chk("R5 addr", 32'(req_addr[0]), 32'({a[AW-1:2], 2'b00}));
                chk("R5 wide", 32'(req_wide[0]), 32'd1);
                chk("R5 insn", ins, VEC[i][37:6]);
                chk("R5 short", 32'(sh), 32'd0);
                chk("R5 latency", 32'(lat), 32'(VEC[i][4:2]));
                chk("R5 reads", 32'(reads), 32'(VEC[i][1:0]));
            end
            @(negedge clk);
            chk("R7 pulse", 32'(insn_valid), 32'd0);
            chk("R7 hold", insn_bits, VEC[i][37:6]);
        end

        // R1: fetch_req while busy is ignored
        @(negedge clk);
        reads = 0;
        fetch_req = 1'b1; fetch_addr = 12'd0; cmode_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        fetch_addr = 12'd2;
        chk("R1 busy", 32'(fetch_ready), 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R1 done", 32'(insn_valid), 32'd1);
        fetch_req = 1'b0;
        chk("R1 first result", insn_bits, 32'h00A00093);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R1 no extra valid", 32'(insn_valid), 32'd0);
        end
        chk("R1 single read", 32'(reads), 32'd1);
        chk("R7 held after idle", insn_bits, 32'h00A00093);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule